// File: doc/BRIEF.md
# Programmable Frame Sync Generator

This block derives a serial bit clock and a periodic frame-sync signal from a fast system clock. It is intended for a serial audio port. One packed control word carries three fields: a bit-clock divider, a frame-sync width and a frame period. The width and the period are counted in bit clocks. The block also supplies per-cycle strobes that mark each edge of the bit clock. A one-cycle start-of-frame strobe lets a transmitter and a receiver align to word boundaries. The nominal system clock is 48 MHz. A stereo port typically uses a 32-bit frame with a 16-bit sync. A mono port typically uses a 256-bit frame.

Generation runs only while both enable inputs are high. The control word and the two polarity selects are static: they may change only while generation is stopped. When generation stops, the counters clear, the bit clock parks at its idle level and frame sync returns to its inactive level.

The frame logic is a small state machine. Its states are FS_IDLE (stopped, or waiting for the first active edge), FS_SYNC (frame sync asserted) and FS_GAP (remainder of the frame, sync deasserted). Its transitions are:
- start: FS_IDLE to FS_SYNC, on the first active edge while running.
- hold: FS_SYNC to FS_SYNC, while the next bit index is still within the width.
- release: FS_SYNC to FS_GAP, once the width is used up.
- wait: FS_GAP to FS_GAP.
- wrap: FS_SYNC or FS_GAP to FS_SYNC, after the last bit of the frame.
- stop: any state to FS_IDLE, when either enable is low.

Top module: `frame_sync_gen`

## Requirements
- R1: While either enable is low, and after reset, the outputs rest as follows. `fs` is at its inactive level and `sof` is 0. Both edge strobes are 0. `bclk` is at its idle level, which is low when `clk_pol`=1 and high when `clk_pol`=0.
- R2: While running, the internal bit clock toggles every (D+1) system cycles, so one bit period is 2*(D+1) cycles. D is the divider field.
- R3: The control word fields are: divider D in bits [9:0], width W in bits [15:10], period P in bits [28:16]. Bits [31:29] have no effect on any output.
- R4: A frame lasts (P+1) bit periods, and `sof` pulses exactly once per frame.
- R5: `fs` is active for the first (W+1) bit periods of each frame. When W >= P, `fs` stays active for the whole frame.
- R6: Generation requires both `gen_en` and `fgen_en` to be high. With only one of them high, the block behaves as stopped.
- R7: `fs_pol`=0 makes `fs` active high. `fs_pol`=1 makes `fs` active low.
- R8: `clk_pol`=1 puts the active (frame-advancing) edge on the rising edge of `bclk`. `clk_pol`=0 puts it on the falling edge. `bclk_rise` and `bclk_fall` are each high for one cycle: the first cycle in which `bclk` shows its new level.
- R9: `sof` and any change of `fs` appear one system cycle after the strobe of the active edge. `sof` is high only together with an active `fs`.
- R10: After enabling from the stopped state, counting the clock edges from the enable, the first active-edge strobe appears after D+1 edges and the first `sof` after D+2 edges. The first frame is complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_en | input | 1 | Clock generator enable |
| fgen_en | input | 1 | Frame generation enable |
| cfg_word | input | 32 | Packed divider, width and period fields |
| clk_pol | input | 1 | 1: rising active edge, 0: falling active edge |
| fs_pol | input | 1 | 1: frame sync active low |
| bclk | output | 1 | Bit clock |
| bclk_rise | output | 1 | Strobe: `bclk` has just risen |
| bclk_fall | output | 1 | Strobe: `bclk` has just fallen |
| fs | output | 1 | Frame sync |
| sof | output | 1 | Start-of-frame strobe |

## Verification
The hardest condition to reach from the ports is the wrap of the frame while the sync is still active, so that FS_SYNC follows itself across the frame boundary. It needs a width at least as large as the period, or a period of zero. The bench reaches it with a control word whose width exceeds a short period, and with another whose period is zero. In both cases it counts the `fs` cycles between successive `sof` pulses. It also reaches the exact restart latency. It stops the block for several cycles, then raises both enables on a falling clock edge and counts edges to the first `sof`.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_SYNC = 2'd1,
        FS_GAP  = 2'd2
    } fs_state_e;

endpackage

// File: rtl/fsg_unpack.sv
module fsg_unpack #(
    parameter int CFG_W = 32,
    parameter int DIV_W = 10,
    parameter int WID_W = 6,
    parameter int PER_W = 13
) (
    input  logic [CFG_W-1:0] cfg,
    output logic [DIV_W-1:0] div_val,
    output logic [WID_W-1:0] wid_val,
    output logic [PER_W-1:0] per_val
);

    localparam int DIV_LSB = 0;
    localparam int WID_LSB = DIV_LSB + DIV_W;
    localparam int PER_LSB = WID_LSB + WID_W;
    localparam int USED_W  = PER_LSB + PER_W;

    assign div_val = cfg[DIV_LSB +: DIV_W];
    assign wid_val = cfg[WID_LSB +: WID_W];
    assign per_val = cfg[PER_LSB +: PER_W];

    // Upper bits beyond the three fields carry no meaning here.
    generate
        if (CFG_W > USED_W) begin : g_spare
            logic unused_spare;
            assign unused_spare = ^cfg[CFG_W-1:USED_W];
        end
    endgenerate

endmodule

// File: rtl/fsg_clkdiv.sv
module fsg_clkdiv #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             lvl,
    output logic             rise_stb,
    output logic             fall_stb
);

    logic [DIV_W-1:0] cnt;
    logic             hit;

    assign hit = (cnt == div_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            lvl      <= 1'b0;
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
        end else if (!run) begin
            cnt      <= '0;
            lvl      <= 1'b0;
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
        end else begin
            rise_stb <= hit && !lvl;
            fall_stb <= hit && lvl;
            if (hit) begin
                cnt <= '0;
                lvl <= ~lvl;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fsg_framer.sv
module fsg_framer
    import fsg_pkg::*;
#(
    parameter int WID_W = 6,
    parameter int PER_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             adv,
    input  logic [WID_W-1:0] wid_val,
    input  logic [PER_W-1:0] per_val,
    output logic             sync_on,
    output logic             sof
);

    localparam int CMP_W = ((PER_W > WID_W) ? PER_W : WID_W) + 1;

    fs_state_e        state, nxt_state;
    logic [PER_W-1:0] bit_cnt, nxt_cnt, nb;
    logic             nxt_sof;
    logic             in_width;

    assign nb       = bit_cnt + 1'b1;
    assign in_width = (CMP_W'(nb) <= CMP_W'(wid_val));

    // Next-state logic
    always_comb begin
        nxt_state = state;
        nxt_cnt   = bit_cnt;
        nxt_sof   = 1'b0;
        if (!run) begin
            nxt_state = FS_IDLE;
            nxt_cnt   = '0;
        end else if (adv) begin
            unique case (state)
                FS_IDLE: begin
                    nxt_state = FS_SYNC;
                    nxt_cnt   = '0;
                    nxt_sof   = 1'b1;
                end
                FS_SYNC, FS_GAP: begin
                    if (bit_cnt == per_val) begin
                        nxt_state = FS_SYNC;
                        nxt_cnt   = '0;
                        nxt_sof   = 1'b1;
                    end else begin
                        nxt_cnt   = nb;
                        nxt_state = in_width ? FS_SYNC : FS_GAP;
                    end
                end
                default: begin
                    nxt_state = FS_IDLE;
                    nxt_cnt   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= FS_IDLE;
            bit_cnt <= '0;
            sof     <= 1'b0;
        end else begin
            state   <= nxt_state;
            bit_cnt <= nxt_cnt;
            sof     <= nxt_sof;
        end
    end

    // Outputs
    always_comb begin
        unique case (state)
            FS_SYNC: sync_on = 1'b1;
            FS_IDLE,
            FS_GAP:  sync_on = 1'b0;
            default: sync_on = 1'b0;
        endcase
    end

endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen #(
    parameter int CFG_W = 32,
    parameter int DIV_W = 10,
    parameter int WID_W = 6,
    parameter int PER_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic             fgen_en,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             clk_pol,
    input  logic             fs_pol,
    output logic             bclk,
    output logic             bclk_rise,
    output logic             bclk_fall,
    output logic             fs,
    output logic             sof
);

    logic             run;
    logic [DIV_W-1:0] div_val;
    logic [WID_W-1:0] wid_val;
    logic [PER_W-1:0] per_val;
    logic             lvl, int_rise, int_fall, sync_on;

    assign run = gen_en & fgen_en;

    fsg_unpack #(
        .CFG_W (CFG_W),
        .DIV_W (DIV_W),
        .WID_W (WID_W),
        .PER_W (PER_W)
    ) u_unpack (
        .cfg     (cfg_word),
        .div_val (div_val),
        .wid_val (wid_val),
        .per_val (per_val)
    );

    fsg_clkdiv #(
        .DIV_W (DIV_W)
    ) u_clkdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .div_val  (div_val),
        .lvl      (lvl),
        .rise_stb (int_rise),
        .fall_stb (int_fall)
    );

    fsg_framer #(
        .WID_W (WID_W),
        .PER_W (PER_W)
    ) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .adv     (int_rise),
        .wid_val (wid_val),
        .per_val (per_val),
        .sync_on (sync_on),
        .sof     (sof)
    );

    // The internal rising edge is always the active edge; the pin
    // polarity decides whether it appears as a rising or falling edge.
    assign bclk      = clk_pol ? lvl : ~lvl;
    assign bclk_rise = clk_pol ? int_rise : int_fall;
    assign bclk_fall = clk_pol ? int_fall : int_rise;
    assign fs        = sync_on ^ fs_pol;

endmodule

// File: rtl/fsg_checker.sv
module fsg_checker (
    input logic clk,
    input logic rst_n,
    input logic gen_en,
    input logic fgen_en,
    input logic clk_pol,
    input logic fs_pol,
    input logic bclk,
    input logic bclk_rise,
    input logic bclk_fall,
    input logic fs,
    input logic sof
);

    logic run;
    assign run = gen_en && fgen_en;

    a_r1_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (fs == fs_pol) && !sof && !bclk_rise && !bclk_fall);

    a_r1_bclk_park: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (bclk == !clk_pol));

    a_r8_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(bclk_rise && bclk_fall));

    a_r8_edge_marked: assert property (@(posedge clk) disable iff (!rst_n)
        ((bclk != $past(bclk)) && $past(run)) |-> (bclk ? bclk_rise : bclk_fall));

    a_r9_sof_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> $past(clk_pol ? bclk_rise : bclk_fall));

    a_r9_sof_with_fs: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> (fs != fs_pol));

endmodule

bind frame_sync_gen fsg_checker u_fsg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gen_en    (gen_en),
    .fgen_en   (fgen_en),
    .clk_pol   (clk_pol),
    .fs_pol    (fs_pol),
    .bclk      (bclk),
    .bclk_rise (bclk_rise),
    .bclk_fall (bclk_fall),
    .fs        (fs),
    .sof       (sof)
);

// File: tb/test_frame_sync_gen.sv
`timescale 1ns/1ps
module test_frame_sync_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen_en = 1'b0;
    logic        fgen_en = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        clk_pol = 1'b1;
    logic        fs_pol = 1'b0;
    logic        bclk, bclk_rise, bclk_fall, fs, sof;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    frame_sync_gen i_frame_sync_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .gen_en    (gen_en),
        .fgen_en   (fgen_en),
        .cfg_word  (cfg_word),
        .clk_pol   (clk_pol),
        .fs_pol    (fs_pol),
        .bclk      (bclk),
        .bclk_rise (bclk_rise),
        .bclk_fall (bclk_fall),
        .fs        (fs),
        .sof       (sof)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pack(input int d, input int w, input int p);
        return (32'(p) << 16) | (32'(w) << 10) | 32'(d);
    endfunction

    task automatic stop_block();
        @(negedge clk);
        gen_en  = 1'b0;
        fgen_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic start_block();
        @(negedge clk);
        gen_en  = 1'b1;
        fgen_en = 1'b1;
    endtask

    task automatic wait_sof(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (sof) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    // Cycles from one sof to the next, and cycles with fs active in between.
    task automatic measure_frame(output int span, output int act_cyc);
        bit seen;
        wait_sof(seen);
        span = 0;
        act_cyc = 0;
        if (!seen) return;
        do begin
            if (fs != fs_pol) act_cyc++;
            span++;
            @(negedge clk);
        end while (!sof && span < 20000);
    endtask

    task automatic t_reset_state();
        check(fs == 1'b0, "R1 fs after reset", fs, 0);
        check(sof == 1'b0, "R1 sof after reset", sof, 0);
        check(bclk == 1'b0, "R1 bclk idle after reset", bclk, 0);
        check(!bclk_rise && !bclk_fall, "R1 strobes after reset", bclk_rise + bclk_fall, 0);
    endtask

    task automatic t_bit_period(input int d);
        int hi, lo;
        stop_block();
        clk_pol  = 1'b1;
        cfg_word = pack(d, 0, 3);
        start_block();
        do @(negedge clk); while (!bclk_rise);
        hi = 0;
        do begin hi++; @(negedge clk); end while (!bclk_fall);
        lo = 0;
        do begin lo++; @(negedge clk); end while (!bclk_rise);
        check(hi == d + 1, "R2 bclk high time", hi, d + 1);
        check(lo == d + 1, "R2 bclk low time", lo, d + 1);
    endtask

    task automatic t_frame(input string tag, input logic [31:0] word,
                           input int d, input int w, input int p);
        int span, act, ew;
        stop_block();
        cfg_word = word;
        start_block();
        measure_frame(span, act);
        ew = (w >= p) ? p : w;
        check(span == (p + 1) * 2 * (d + 1), {tag, " R4 frame span"}, span, (p + 1) * 2 * (d + 1));
        check(act == (ew + 1) * 2 * (d + 1), {tag, " R5 fs active cycles"}, act, (ew + 1) * 2 * (d + 1));
    endtask

    task automatic t_single_enable();
        int events;
        stop_block();
        cfg_word = pack(0, 0, 1);
        events = 0;
        gen_en = 1'b1;
        repeat (40) begin
            @(negedge clk);
            if (bclk_rise || bclk_fall || sof || fs != fs_pol) events++;
        end
        check(events == 0, "R6 gen_en alone", events, 0);
        gen_en  = 1'b0;
        fgen_en = 1'b1;
        repeat (40) begin
            @(negedge clk);
            if (bclk_rise || bclk_fall || sof || fs != fs_pol) events++;
        end
        check(events == 0, "R6 fgen_en alone", events, 0);
        fgen_en = 1'b0;
    endtask

    task automatic t_fs_polarity();
        int span, act;
        stop_block();
        fs_pol = 1'b1;
        @(negedge clk);
        check(fs == 1'b1, "R7 inactive level high when active low", fs, 1);
        cfg_word = pack(1, 2, 7);
        start_block();
        measure_frame(span, act);
        check(act == 3 * 4, "R7 active-low fs cycles", act, 12);
        stop_block();
        fs_pol = 1'b0;
    endtask

    task automatic t_clk_polarity();
        int bad, sofs;
        bit prev_fall;
        stop_block();
        clk_pol = 1'b0;
        @(negedge clk);
        check(bclk == 1'b1, "R1 R8 idle bclk high for falling mode", bclk, 1);
        cfg_word = pack(2, 1, 3);
        start_block();
        bad = 0;
        sofs = 0;
        prev_fall = 1'b0;
        repeat (200) begin
            @(negedge clk);
            if (sof) begin
                sofs++;
                if (!prev_fall) bad++;
            end
            prev_fall = bclk_fall;
        end
        check(sofs > 0 && bad == 0, "R8 R9 sof one cycle after falling strobe", bad, 0);
        stop_block();
        clk_pol = 1'b1;
    endtask

    task automatic t_restart(input int d);
        int k;
        stop_block();
        cfg_word = pack(d, 0, 5);
        start_block();
        k = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            k++;
            if (sof) break;
        end
        check(k == d + 2, "R10 first sof latency", k, d + 2);
        check(fs == 1'b1, "R10 first frame starts with fs", fs, 1);
    endtask

    task automatic t_high_bits();
        int s0, a0, s1, a1;
        stop_block();
        cfg_word = pack(1, 3, 9);
        start_block();
        measure_frame(s0, a0);
        stop_block();
        cfg_word = pack(1, 3, 9) | 32'hE000_0000;
        start_block();
        measure_frame(s1, a1);
        check(s1 == s0 && s1 == 40, "R3 span with spare bits set", s1, 40);
        check(a1 == a0 && a1 == 16, "R3 fs with spare bits set", a1, 16);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_bit_period(0);
        t_bit_period(3);
        t_frame("stereo", pack(1, 15, 31), 1, 15, 31);
        t_frame("mono", pack(0, 0, 255), 0, 0, 255);
        t_frame("wide", pack(0, 10, 3), 0, 10, 3);
        t_frame("p0", pack(2, 0, 0), 2, 0, 0);
        t_frame("fields", pack(5, 2, 6), 5, 2, 6);
        t_high_bits();
        t_single_enable();
        t_fs_polarity();
        t_clk_polarity();
        t_restart(0);
        t_restart(4);
        stop_block();
        check(fs == 1'b0 && bclk == 1'b0 && !sof, "R1 stopped again", fs + bclk + sof, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule